// File: doc/BRIEF.md
# Host Memory Access Port with Write Arbitration

This block sits between a host processor bus and a 32K-word store of 16-bit words. The host presents a 16-bit address, and a mode input picks how it is read. In word mode the upper fifteen bits give the word and the lowest bit is ignored. In byte mode the lowest bit picks one half of the word. Word addresses below 0x20 reach a bank of 32 registers. Every other address reaches static RAM. Both regions follow the same simple synchronous handshake. Each register carries a fixed per-bit writable mask, so a host write cannot disturb read-only bits.

A second port serves the internal device logic. It uses 15-bit word addresses and can read and write any register or RAM word. The device port always writes whole words, read-only register bits included. Only one write reaches storage per cycle. When both sides write the same shared control word in the same cycle, the two values are merged bit by bit through a fixed ownership mask. When they collide any other way, the device goes first and the host is held for a cycle.

Top module: `hostmem_arb`

## Requirements
- R1: In word mode (`byte_mode`=0), `h_addr[15:1]` is the word address and `h_addr[0]` has no effect on reads or writes.
- R2: In byte mode, `h_addr[0]`=0 selects bits 15:8 and `h_addr[0]`=1 selects bits 7:0 of the word. A byte write takes its data from `h_wdata[7:0]` and leaves the other byte unchanged. A byte read returns the selected byte on `h_rdata[7:0]` with `h_rdata[15:8]`=0.
- R3: Word addresses 0x00–0x1F select registers and 0x20–0x7FFF select RAM. RAM decodes only the low `RAM_AW` word-address bits (default 10), so higher RAM addresses alias.
- R4: A read presented in one cycle returns data on `h_rdata`/`d_rdata` in the next cycle. The data is the content before any write in the request cycle. The output holds until the next read on that port.
- R5: A host write to register i gives new = (old & ~m) | (wdata & m), where m=0xFFFF for i=0, m=0x0000 for i=1, and otherwise m = {3'b111, i[4:0], 3'b000, ~i[4:0]}. A device write replaces all 16 bits.
- R6: Both ports can write and read every RAM word, and data written by one port is read back by the other.
- R7: Shared words are 0x20–0x2F. When both ports write the same shared word in one cycle, the bits in `HOST_OWN`=0xF00F take the host value within its byte lane. All other bits take the device value. Host-owned bits outside the host lane keep their old value. `h_ready` stays 1.
- R8: Any other cycle with both ports writing commits only the device write and drives `h_ready`=0. The host keeps its request, and its write commits in the first cycle with `h_ready`=1.
- R9: After reset all registers read 0, `h_rdata` and `d_rdata` are 0, and `h_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = byte addressing on the host port, 0 = word addressing |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 16 | Host address |
| h_wdata | input | 16 | Host write data (byte in bits 7:0 in byte mode) |
| h_ready | output | 1 | Low when a host write is held this cycle |
| h_rdata | output | 16 | Host read data, one cycle after the request |
| d_req | input | 1 | Device access request |
| d_we | input | 1 | Device write (1) or read (0) |
| d_addr | input | 15 | Device word address |
| d_wdata | input | 16 | Device write data |
| d_rdata | output | 16 | Device read data, one cycle after the request |

## Verification
The bench sweeps every register with distinct values and targets the read-only masks at bit level. A design that ignored the mask, or applied it to device writes, would return the wrong mixed word. It writes every shared word from both ports in the same cycle, in word mode and in both byte lanes. A design that let one side win, or dropped the untouched host-owned bits, would show the loser's bits or corrupted bits. It also provokes held writes. It checks that `h_ready` falls only then and that a read in the held cycle still sees the old value. A design that dropped the held write, or let it land early, fails those checks. Full sweeps of the RAM in both address modes catch a swapped byte lane, a decoded address bit 0 in word mode, and broken aliasing.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int HM_DW = 16;
  localparam int HM_BW = HM_DW / 2;

  // Writable-bit mask of register i for host writes.
  function automatic logic [HM_DW-1:0] reg_wmask(input logic [4:0] idx);
    if (idx == 5'd0)      return 16'hFFFF;
    else if (idx == 5'd1) return 16'h0000;
    else                  return {3'b111, idx, 3'b000, ~idx};
  endfunction

  // Bit lanes touched by a host access.
  function automatic logic [HM_DW-1:0] lane_mask(input logic bmode, input logic a0);
    if (!bmode) return '1;
    return a0 ? {{HM_BW{1'b0}}, {HM_BW{1'b1}}} : {{HM_BW{1'b1}}, {HM_BW{1'b0}}};
  endfunction
endpackage

// File: rtl/hm_host_decode.sv
module hm_host_decode
  import hm_pkg::*;
#(
  parameter int HAW = 16,
  localparam int WAW = HAW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_mode,
  input  logic [HAW-1:0]   h_addr,
  input  logic [HM_DW-1:0] h_wdata,
  output logic [WAW-1:0]   word_addr,
  output logic             lo_sel,
  output logic [HM_DW-1:0] lane_bm,
  output logic [HM_DW-1:0] wdata_al
);
  assign word_addr = h_addr[HAW-1:1];
  assign lo_sel    = h_addr[0];
  assign lane_bm   = lane_mask(byte_mode, h_addr[0]);
  assign wdata_al  = byte_mode ? {2{h_wdata[HM_BW-1:0]}} : h_wdata;

  // R2: one byte lane at a time in byte mode
  p_byte_lane_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> ($countones(lane_bm) == HM_BW));
  // R1: word mode touches the whole word whatever bit 0 is
  p_word_lane_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_mode |-> (lane_bm == '1));
endmodule

// File: rtl/hm_write_arb.sv
module hm_write_arb
  import hm_pkg::*;
#(
  parameter int             WAW          = 15,
  parameter int             SHARED_BASE  = 32,
  parameter int             SHARED_WORDS = 16,
  parameter logic [HM_DW-1:0] HOST_OWN   = 16'hF00F,
  localparam logic [WAW-1:0] SH_LO = WAW'(SHARED_BASE),
  localparam logic [WAW-1:0] SH_HI = WAW'(SHARED_BASE + SHARED_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_wr,
  input  logic [WAW-1:0]   h_addr,
  input  logic [HM_DW-1:0] h_data,
  input  logic [HM_DW-1:0] h_bm,
  input  logic             d_wr,
  input  logic [WAW-1:0]   d_addr,
  input  logic [HM_DW-1:0] d_data,
  output logic             w_en,
  output logic [WAW-1:0]   w_addr,
  output logic [HM_DW-1:0] w_data,
  output logic [HM_DW-1:0] w_bm,
  output logic             w_dev,
  output logic             h_ready
);
  logic same_word, shared_word, merge_ev, clash_ev;
  logic [HM_DW-1:0] host_bits;

  assign same_word   = (h_addr == d_addr);
  assign shared_word = (d_addr >= SH_LO) && (d_addr < SH_HI);
  assign merge_ev    = h_wr && d_wr && same_word && shared_word;
  assign clash_ev    = h_wr && d_wr && !merge_ev;
  assign host_bits   = h_bm & HOST_OWN;
  assign h_ready     = !clash_ev;

  always_comb begin
    w_en   = h_wr || d_wr;
    w_dev  = d_wr;
    w_addr = d_wr ? d_addr : h_addr;
    if (merge_ev) begin
      w_bm   = host_bits | ~HOST_OWN;
      w_data = (h_data & host_bits) | (d_data & ~HOST_OWN);
    end else if (d_wr) begin
      w_bm   = '1;
      w_data = d_data;
    end else begin
      w_bm   = h_bm;
      w_data = h_data;
    end
  end

  // R8: the host is held only when both sides write
  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !h_ready |-> (h_wr && d_wr && w_en && w_dev && w_addr == d_addr));
  // R7: a same-word write to a shared word is never held
  p_merge_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && d_wr && h_addr == d_addr && d_addr >= SH_LO && d_addr < SH_HI) |-> h_ready);
endmodule

// File: rtl/hm_regfile.sv
module hm_regfile
  import hm_pkg::*;
#(
  parameter int NREG = 32,
  parameter int WAW  = 15,
  localparam int RIW = $clog2(NREG),
  localparam logic [WAW-1:0] NREG_W = WAW'(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             w_en,
  input  logic [WAW-1:0]   w_addr,
  input  logic [HM_DW-1:0] w_data,
  input  logic [HM_DW-1:0] w_bm,
  input  logic             w_dev,
  input  logic             re_a,
  input  logic [RIW-1:0]   ra_a,
  input  logic             re_b,
  input  logic [RIW-1:0]   ra_b,
  output logic [HM_DW-1:0] q_a,
  output logic [HM_DW-1:0] q_b
);
  logic [HM_DW-1:0] regs [NREG];
  logic             reg_hit;
  logic [RIW-1:0]   w_idx;

  assign reg_hit = w_en && (w_addr < NREG_W);
  assign w_idx   = w_addr[RIW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      q_a <= '0;
      q_b <= '0;
    end else begin
      if (re_a) q_a <= regs[ra_a];
      if (re_b) q_b <= regs[ra_b];
      if (reg_hit) regs[w_idx] <= (regs[w_idx] & ~w_bm) | (w_data & w_bm);
    end
  end

  // R5: a host write never changes a read-only register bit
  p_ro_bits_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && !w_dev) |=>
      ((regs[$past(w_idx)] & ~reg_wmask(5'($past(w_idx)))) ==
       ($past(regs[w_idx]) & ~reg_wmask(5'($past(w_idx))))));
endmodule

// File: rtl/hm_ram.sv
module hm_ram
  import hm_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int WAW    = 15,
  parameter int NRD    = 2,
  parameter int NREG   = 32,
  localparam int DEPTH = 1 << RAM_AW,
  localparam logic [WAW-1:0] NREG_W = WAW'(NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        w_en,
  input  logic [WAW-1:0]              w_addr,
  input  logic [HM_DW-1:0]            w_data,
  input  logic [HM_DW-1:0]            w_bm,
  input  logic [NRD-1:0]              re,
  input  logic [NRD-1:0][RAM_AW-1:0]  ra,
  output logic [NRD-1:0][HM_DW-1:0]   q
);
  logic [HM_DW-1:0]  mem [DEPTH];
  logic              ram_hit;
  logic [RAM_AW-1:0] w_idx;

  assign ram_hit = w_en && (w_addr >= NREG_W);
  assign w_idx   = w_addr[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (ram_hit) mem[w_idx] <= (mem[w_idx] & ~w_bm) | (w_data & w_bm);
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)     q[p] <= '0;
      else if (re[p]) q[p] <= mem[ra[p]];
    end
  end

  // R2: bits outside the write mask keep their value
  p_mask_preserve_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit |=> ((mem[$past(w_idx)] & ~$past(w_bm)) === ($past(mem[w_idx]) & ~$past(w_bm))));
endmodule

// File: rtl/hostmem_arb.sv
module hostmem_arb
  import hm_pkg::*;
#(
  parameter int             HAW          = 16,
  parameter int             NREG         = 32,
  parameter int             RAM_AW       = 10,
  parameter int             SHARED_BASE  = 32,
  parameter int             SHARED_WORDS = 16,
  parameter logic [HM_DW-1:0] HOST_OWN   = 16'hF00F,
  localparam int WAW = HAW - 1,
  localparam int RIW = $clog2(NREG),
  localparam logic [WAW-1:0] NREG_W = WAW'(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_mode,
  input  logic             h_req,
  input  logic             h_we,
  input  logic [HAW-1:0]   h_addr,
  input  logic [HM_DW-1:0] h_wdata,
  output logic             h_ready,
  output logic [HM_DW-1:0] h_rdata,
  input  logic             d_req,
  input  logic             d_we,
  input  logic [WAW-1:0]   d_addr,
  input  logic [HM_DW-1:0] d_wdata,
  output logic [HM_DW-1:0] d_rdata
);
  logic [WAW-1:0]   h_wa;
  logic             h_lo;
  logic [HM_DW-1:0] h_lane, h_wd, h_bm;
  logic             h_rd, d_rd, h_is_reg, d_is_reg;

  hm_host_decode #(.HAW(HAW)) u_dec (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .h_addr(h_addr),
    .h_wdata(h_wdata), .word_addr(h_wa), .lo_sel(h_lo), .lane_bm(h_lane),
    .wdata_al(h_wd));

  assign h_is_reg = (h_wa < NREG_W);
  assign d_is_reg = (d_addr < NREG_W);
  assign h_bm     = h_is_reg ? (h_lane & reg_wmask(5'(h_wa[RIW-1:0]))) : h_lane;
  assign h_rd     = h_req && !h_we;
  assign d_rd     = d_req && !d_we;

  logic             w_en, w_dev;
  logic [WAW-1:0]   w_addr;
  logic [HM_DW-1:0] w_data, w_bm;

  hm_write_arb #(.WAW(WAW), .SHARED_BASE(SHARED_BASE), .SHARED_WORDS(SHARED_WORDS),
                 .HOST_OWN(HOST_OWN)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_req && h_we), .h_addr(h_wa), .h_data(h_wd), .h_bm(h_bm),
    .d_wr(d_req && d_we), .d_addr(d_addr), .d_data(d_wdata),
    .w_en(w_en), .w_addr(w_addr), .w_data(w_data), .w_bm(w_bm), .w_dev(w_dev),
    .h_ready(h_ready));

  logic [HM_DW-1:0] rq_h, rq_d;
  hm_regfile #(.NREG(NREG), .WAW(WAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .w_en(w_en), .w_addr(w_addr), .w_data(w_data),
    .w_bm(w_bm), .w_dev(w_dev),
    .re_a(h_rd && h_is_reg), .ra_a(h_wa[RIW-1:0]),
    .re_b(d_rd && d_is_reg), .ra_b(d_addr[RIW-1:0]),
    .q_a(rq_h), .q_b(rq_d));

  logic [1:0][RAM_AW-1:0] ram_ra;
  logic [1:0][HM_DW-1:0]  ram_q;
  assign ram_ra[0] = h_wa[RAM_AW-1:0];
  assign ram_ra[1] = d_addr[RAM_AW-1:0];

  hm_ram #(.RAM_AW(RAM_AW), .WAW(WAW), .NRD(2), .NREG(NREG)) u_ram (
    .clk(clk), .rst_n(rst_n), .w_en(w_en), .w_addr(w_addr), .w_data(w_data),
    .w_bm(w_bm), .re({d_rd && !d_is_reg, h_rd && !h_is_reg}), .ra(ram_ra),
    .q(ram_q));

  // Per-port read context, captured with the request
  logic h_sel_reg, h_byte, h_lo_q, d_sel_reg;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_sel_reg <= 1'b1;
      h_byte    <= 1'b0;
      h_lo_q    <= 1'b0;
      d_sel_reg <= 1'b1;
    end else begin
      if (h_rd) begin
        h_sel_reg <= h_is_reg;
        h_byte    <= byte_mode;
        h_lo_q    <= h_lo;
      end
      if (d_rd) d_sel_reg <= d_is_reg;
    end
  end

  logic [HM_DW-1:0] h_word;
  assign h_word  = h_sel_reg ? rq_h : ram_q[0];
  assign h_rdata = !h_byte ? h_word :
                   {{HM_BW{1'b0}}, h_lo_q ? h_word[HM_BW-1:0] : h_word[HM_DW-1:HM_BW]};
  assign d_rdata = d_sel_reg ? rq_d : ram_q[1];

  // R4: read data holds while no read is requested
  p_hrdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> $stable(h_rdata));
  p_drdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !d_rd |=> $stable(d_rdata));
  // R2: a byte read clears the upper byte
  p_byte_read_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && byte_mode) |=> (h_rdata[HM_DW-1:HM_BW] == '0));
endmodule

// File: tb/tb_hostmem_arb.sv
module tb_hostmem_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0;
  logic h_req = 1'b0, h_we = 1'b0;
  logic [15:0] h_addr = '0, h_wdata = '0;
  logic h_ready;
  logic [15:0] h_rdata;
  logic d_req = 1'b0, d_we = 1'b0;
  logic [14:0] d_addr = '0;
  logic [15:0] d_wdata = '0;
  logic [15:0] d_rdata;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  hostmem_arb dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_ready(h_ready), .h_rdata(h_rdata),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_rdata(d_rdata));

  function automatic logic [15:0] wmask(input int i);
    logic [4:0] k;
    k = 5'(i);
    if (i == 0) return 16'hFFFF;
    if (i == 1) return 16'h0000;
    return {3'b111, k, 3'b000, ~k};
  endfunction

  function automatic logic [15:0] pat_f(input int w);
    return 16'(w * 40503) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] pat_g(input int w);
    return 16'(w * 12345 + 777) ^ 16'hC33C;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic h_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_req = 0; h_we = 0;
  endtask

  task automatic h_read(input logic [15:0] a, output logic [15:0] q);
    @(negedge clk);
    h_req = 1; h_we = 0; h_addr = a;
    @(negedge clk);
    h_req = 0;
    q = h_rdata;
  endtask

  task automatic d_write(input logic [14:0] a, input logic [15:0] d);
    @(negedge clk);
    d_req = 1; d_we = 1; d_addr = a; d_wdata = d;
    @(negedge clk);
    d_req = 0; d_we = 0;
  endtask

  task automatic d_read(input logic [14:0] a, output logic [15:0] q);
    @(negedge clk);
    d_req = 1; d_we = 0; d_addr = a;
    @(negedge clk);
    d_req = 0;
    q = d_rdata;
  endtask

  initial begin
    #4000000;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] q, exp, old, hv, dv, lane, hm, dm;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R9: reset state
    chk("R9 ready", {15'd0, h_ready}, 16'h0001);
    chk("R9 h_rdata", h_rdata, 16'h0000);
    chk("R9 d_rdata", d_rdata, 16'h0000);
    for (int i = 0; i < 32; i++) begin
      h_read(16'(i * 2), q);
      chk("R9 reg clear", q, 16'h0000);
    end

    // R5: register masks, word mode
    for (int i = 0; i < 32; i++) begin
      dv = 16'hC3A5 ^ 16'(i << 3);
      hv = ~dv ^ 16'(i);
      d_write(15'(i), dv);
      h_write(16'(i * 2 + 1), hv);
      exp = (dv & ~wmask(i)) | (hv & wmask(i));
      h_read(16'(i * 2), q);
      chk("R5 reg host merge", q, exp);
      d_read(15'(i), q);
      chk("R5 reg device view", q, exp);
    end
    // R5: device writes overwrite read-only bits
    d_write(15'd1, 16'h9876);
    d_read(15'd1, q);
    chk("R5 device full write", q, 16'h9876);

    // R5 + R2: byte-mode write into a register
    d_write(15'd5, 16'h0000);
    byte_mode = 1;
    h_write({15'd5, 1'b1}, 16'hABFF);
    h_write({15'd5, 1'b0}, 16'h12FF);
    byte_mode = 0;
    h_read(16'd10, q);
    chk("R5 byte reg write", q, 16'hFFFF & wmask(5));

    // R1 + R6: host writes (bit 0 varies), device reads
    for (int w = 32; w < 1024; w++) h_write({15'(w), 1'(w)}, pat_g(w));
    for (int w = 32; w < 1024; w++) begin
      d_read(15'(w), q);
      chk("R1 R6 host->device", q, pat_g(w));
    end
    for (int w = 32; w < 1024; w++) d_write(15'(w), pat_f(w));
    for (int w = 32; w < 1024; w++) begin
      h_read({15'(w), ~1'(w)}, q);
      chk("R1 R6 device->host", q, pat_f(w));
    end

    // R2: byte reads and byte writes over a RAM window
    byte_mode = 1;
    for (int w = 256; w < 320; w++) begin
      h_read({15'(w), 1'b0}, q);
      chk("R2 byte read upper", q, {8'h00, pat_f(w)[15:8]});
      h_read({15'(w), 1'b1}, q);
      chk("R2 byte read lower", q, {8'h00, pat_f(w)[7:0]});
      h_write({15'(w), w[0]}, {8'hEE, 8'(w)});
    end
    byte_mode = 0;
    for (int w = 256; w < 320; w++) begin
      exp = w[0] ? {pat_f(w)[15:8], 8'(w)} : {8'(w), pat_f(w)[7:0]};
      d_read(15'(w), q);
      chk("R2 byte write lane", q, exp);
    end

    // R3: region decode and RAM aliasing
    d_write(15'h0400, 16'h1111);
    h_write(16'h0000, 16'hBEEF);
    d_read(15'h0400, q);
    chk("R3 reg write misses RAM", q, 16'h1111);
    h_read(16'h0000, q);
    chk("R3 reg 0", q, 16'hBEEF);
    h_write({15'h0420, 1'b0}, 16'h7E57);
    d_read(15'h0020, q);
    chk("R3 RAM alias", q, 16'h7E57);

    // R4: read in the same cycle as a write sees the old value
    d_write(15'h0060, 16'hAAAA);
    @(negedge clk);
    d_req = 1; d_we = 1; d_addr = 15'h0060; d_wdata = 16'h5555;
    h_req = 1; h_we = 0; h_addr = 16'h00C0;
    @(negedge clk);
    d_req = 0; d_we = 0; h_req = 0;
    chk("R4 read-before-write", h_rdata, 16'hAAAA);
    repeat (2) @(negedge clk);
    chk("R4 hold", h_rdata, 16'hAAAA);
    h_read(16'h00C0, q);
    chk("R4 new value", q, 16'h5555);

    // R7: merged shared writes, word mode
    for (int k = 0; k < 16; k++) begin
      hv = pat_g(k + 900);
      dv = pat_f(k + 901);
      @(negedge clk);
      h_req = 1; h_we = 1; h_addr = {15'(32 + k), 1'b0}; h_wdata = hv;
      d_req = 1; d_we = 1; d_addr = 15'(32 + k); d_wdata = dv;
      #1;
      chk("R7 merge ready", {15'd0, h_ready}, 16'h0001);
      @(negedge clk);
      h_req = 0; h_we = 0; d_req = 0; d_we = 0;
      d_read(15'(32 + k), q);
      chk("R7 merge word", q, (hv & 16'hF00F) | (dv & 16'h0FF0));
    end
    // R7: merged shared writes, byte mode, both lanes
    for (int k = 0; k < 8; k++) begin
      for (int ln = 0; ln < 2; ln++) begin
        old = pat_f(k * 7 + ln);
        d_write(15'(40 + k), old);
        hv = {8'h00, 8'(k * 37 + ln * 91 + 5)};
        dv = pat_g(k * 3 + ln);
        byte_mode = 1;
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = {15'(40 + k), 1'(ln)}; h_wdata = hv;
        d_req = 1; d_we = 1; d_addr = 15'(40 + k); d_wdata = dv;
        #1;
        chk("R7 merge ready byte", {15'd0, h_ready}, 16'h0001);
        @(negedge clk);
        h_req = 0; h_we = 0; d_req = 0; d_we = 0;
        byte_mode = 0;
        lane = (ln == 1) ? 16'h00FF : 16'hFF00;
        hm = lane & 16'hF00F;
        dm = 16'h0FF0;
        exp = ({hv[7:0], hv[7:0]} & hm) | (dv & dm) | (old & ~(hm | dm));
        d_read(15'(40 + k), q);
        chk("R7 merge byte", q, exp);
      end
    end

    // R8: different addresses, device first, host held one cycle
    d_write(15'h0040, 16'h0F0F);
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = 16'h0080; h_wdata = 16'h1357;
    d_req = 1; d_we = 1; d_addr = 15'h0041; d_wdata = 16'h2468;
    #1;
    chk("R8 held", {15'd0, h_ready}, 16'h0000);
    @(negedge clk);
    d_we = 0; d_addr = 15'h0040;
    #1;
    chk("R8 released", {15'd0, h_ready}, 16'h0001);
    @(negedge clk);
    h_req = 0; h_we = 0; d_req = 0;
    chk("R8 no early host write", d_rdata, 16'h0F0F);
    h_read(16'h0080, q);
    chk("R8 host write lands", q, 16'h1357);
    h_read(16'h0082, q);
    chk("R8 device write lands", q, 16'h2468);

    // R8: same non-shared word, host commits last
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = 16'h00A0; h_wdata = 16'hCAFE;
    d_req = 1; d_we = 1; d_addr = 15'h0050; d_wdata = 16'hD00D;
    #1;
    chk("R8 same word held", {15'd0, h_ready}, 16'h0000);
    @(negedge clk);
    d_req = 0; d_we = 0;
    @(negedge clk);
    h_req = 0; h_we = 0;
    d_read(15'h0050, q);
    chk("R8 same word final", q, 16'hCAFE);

    // R8: register clash
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = 16'h0000; h_wdata = 16'h0001;
    d_req = 1; d_we = 1; d_addr = 15'h0003; d_wdata = 16'h0002;
    #1;
    chk("R8 reg clash held", {15'd0, h_ready}, 16'h0000);
    @(negedge clk);
    d_req = 0; d_we = 0;
    @(negedge clk);
    h_req = 0; h_we = 0;
    h_read(16'h0000, q);
    chk("R8 reg host", q, 16'h0001);
    h_read(16'h0006, q);
    chk("R8 reg device", q, 16'h0002);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule